// File: doc/BRIEF.md
# Two-Plane NAND Page Read Sequencer

This block is the host-side engine that fetches the same page from both planes of a two-plane NAND device in a single array access. A request carries two row addresses, one for each plane, plus a starting column and a byte count. The block first checks that the request is one the device can serve. It then issues a plane-address group for each plane and a single confirm opcode, and waits on the ready/busy line. Once the device is ready, it unloads each plane's page register in turn. For each plane it issues a full-address select, then a column-change pair, and then reads the bytes.

Bytes leave on a simple stream. Each byte carries its plane number and a marker on the final byte of that plane. When the block finishes, it gives a one-cycle completion pulse together with a status code: 0 for success, 1 for a rejected request, 2 for a ready/busy timeout. Each command or address byte takes two clocks: write strobe low, then high, with the bus held steady across the rising edge. Each data byte also takes two clocks: read strobe low, then high. The block samples the bus on the clock edge that raises the read strobe.

The control is one state machine with these states:
- IDLE waits for a start.
- SETUP drives the nine setup bytes.
- WB is a short settle delay after the confirm.
- BUSY waits for ready, bounded by a timeout.
- UNLOAD drives the ten select bytes for one plane.
- WHR is a settle delay before reading.
- READ moves the bytes.
- DONE gives the pulse.

The transitions are:
- IDLE→SETUP on a valid start; IDLE→DONE on a rejected start.
- SETUP→WB after the confirm.
- WB→BUSY when the delay ends.
- BUSY→UNLOAD on ready; BUSY→DONE on timeout.
- UNLOAD→WHR after the last select byte; WHR→READ when the delay ends.
- READ→UNLOAD after plane 0; READ→DONE after plane 1.
- DONE→IDLE.

Top module: `mpr_seq`

## Requirements
- R1: During and right after reset, all of the following hold: write strobe and read strobe high, command latch and address latch low, bus output enable low, `busy_o` low, `done_o` low and `rd_valid_o` low.
- R2: A start is rejected if `row_b_i` differs from `row_a_i` in any bit other than bit PAGE_BITS (the plane bit, the lowest block bit), or if that bit of `row_a_i` is 1. This covers a differing page offset. A rejected start ends with status 1 and drives no strobe.
- R3: A start is rejected with status 1 if any of these holds: the column is 8640 or more, the count is 0, or column plus count exceeds 8640. Column plus count equal to 8640 is accepted.
- R4: Setup drives, in order: opcode 60h, the three bytes of `row_a_i` (least significant byte first), opcode 60h, the three bytes of `row_b_i`, and opcode 30h. Opcodes are driven with the command latch high, address bytes with the address latch high, and the two latches are never high together.
- R5: No unload command and no read strobe is issued while ready/busy is low after the confirm.
- R6: If ready/busy stays low for TMO_CYCLES clocks, the operation ends with status 2. No unload bytes follow and no data is streamed.
- R7: Each plane is unloaded with the following sequence, plane 0 first, then plane 1 using `row_b_i`: opcode 00h, column low byte, column high byte, the three row bytes, opcode 05h, column low byte, column high byte, opcode E0h.
- R8: For each plane, `cnt_i` bytes stream out, from ascending column addresses starting at `col_i`. `rd_plane_o` gives the plane, and `rd_last_o` is set only on that plane's final byte. Plane 0's bytes all come before plane 1's.
- R9: After the last byte, `done_o` pulses high for exactly one cycle with status 0, and `busy_o` is low on the next cycle.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse, taken in IDLE |
| row_a_i | input | 24 | Row address for plane 0 |
| row_b_i | input | 24 | Row address for plane 1 |
| col_i | input | 14 | First column to read |
| cnt_i | input | 14 | Bytes to read per plane |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 rejected, 2 timeout |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_io_o | output | 8 | Bus output value |
| nand_io_oe_o | output | 1 | Bus output enable |
| nand_io_i | input | 8 | Bus input value |
| nand_rb_n_i | input | 1 | Ready (1) / busy (0) |
| rd_valid_o | output | 1 | Stream byte valid |
| rd_data_o | output | 8 | Stream byte |
| rd_plane_o | output | 1 | Plane of stream byte |
| rd_last_o | output | 1 | Final byte of this plane |

## Verification
A wrong step index or phase shows up within two clocks of the fault as a misordered or duplicated byte in the captured command/address log. A wrong plane flag shows up as an unload addressed to the wrong row, and as data the device model returns for the other plane. A corrupted remaining-count register appears at the end of the plane as a stream that is too long or too short, or as a misplaced last marker. A stuck busy-wait either streams data before ready rises, or fails to report a timeout within TMO_CYCLES.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_BADREQ  = 2'd1,
        ST_TIMEOUT = 2'd2
    } mpr_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_WB,
        S_BUSY,
        S_UNLOAD,
        S_WHR,
        S_READ,
        S_DONE
    } mpr_state_e;

    localparam logic [7:0] OP_PLANE_SEL = 8'h60;
    localparam logic [7:0] OP_CONFIRM   = 8'h30;
    localparam logic [7:0] OP_READ_ADDR = 8'h00;
    localparam logic [7:0] OP_COL_CHG   = 8'h05;
    localparam logic [7:0] OP_COL_GO    = 8'hE0;
endpackage

// File: rtl/mpr_req_check.sv
module mpr_req_check #(
    parameter int ROW_W      = 24,
    parameter int COL_W      = 14,
    parameter int PAGE_BITS  = 8,
    parameter int PAGE_BYTES = 8640
) (
    input  logic [ROW_W-1:0] row_a,
    input  logic [ROW_W-1:0] row_b,
    input  logic [COL_W-1:0] col,
    input  logic [COL_W-1:0] cnt,
    output logic             ok
);
    localparam logic [ROW_W-1:0] PLANE_MASK = ROW_W'(1) << PAGE_BITS;
    localparam logic [COL_W:0]   PAGE_LIM   = PAGE_BYTES[COL_W:0];

    logic           pair_ok;
    logic           span_ok;
    logic [COL_W:0] end_col;

    always_comb begin
        end_col = {1'b0, col} + {1'b0, cnt};
        pair_ok = !row_a[PAGE_BITS] && (row_b == (row_a | PLANE_MASK));
        span_ok = (cnt != '0) && ({1'b0, col} < PAGE_LIM) && (end_col <= PAGE_LIM);
        ok      = pair_ok && span_ok;
    end
endmodule

// File: rtl/mpr_step_rom.sv
module mpr_step_rom #(
    parameter int ROW_W = 24,
    parameter int COL_W = 14,
    parameter int IDX_W = 4
) (
    input  logic             unload,
    input  logic [IDX_W-1:0] idx,
    input  logic [ROW_W-1:0] row_a,
    input  logic [ROW_W-1:0] row_b,
    input  logic             plane,
    input  logic [COL_W-1:0] col,
    output logic             is_cmd,
    output logic [7:0]       byte_o
);
    import mpr_pkg::*;

    localparam int RB  = ROW_W / 8;
    localparam int RBW = (RB > 1) ? $clog2(RB) : 1;

    logic [7:0]  a_byte [RB];
    logic [7:0]  b_byte [RB];
    logic [7:0]  u_byte [RB];
    logic [15:0] col16;

    for (genvar k = 0; k < RB; k++) begin : g_rowbytes
        assign a_byte[k] = row_a[8*k +: 8];
        assign b_byte[k] = row_b[8*k +: 8];
        assign u_byte[k] = plane ? row_b[8*k +: 8] : row_a[8*k +: 8];
    end

    assign col16 = 16'(col);

    always_comb begin
        int i;
        i      = int'(idx);
        is_cmd = 1'b0;
        byte_o = 8'h00;
        if (!unload) begin
            if (i == 0 || i == RB + 1) begin
                is_cmd = 1'b1;
                byte_o = OP_PLANE_SEL;
            end else if (i <= RB) begin
                byte_o = a_byte[RBW'(i - 1)];
            end else if (i <= 2 * RB + 1) begin
                byte_o = b_byte[RBW'(i - RB - 2)];
            end else begin
                is_cmd = 1'b1;
                byte_o = OP_CONFIRM;
            end
        end else begin
            if (i == 0) begin
                is_cmd = 1'b1;
                byte_o = OP_READ_ADDR;
            end else if (i == 1 || i == RB + 4) begin
                byte_o = col16[7:0];
            end else if (i == 2 || i == RB + 5) begin
                byte_o = col16[15:8];
            end else if (i <= RB + 2) begin
                byte_o = u_byte[RBW'(i - 3)];
            end else if (i == RB + 3) begin
                is_cmd = 1'b1;
                byte_o = OP_COL_CHG;
            end else begin
                is_cmd = 1'b1;
                byte_o = OP_COL_GO;
            end
        end
    end
endmodule

// File: rtl/mpr_wait_timer.sv
module mpr_wait_timer #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/mpr_seq.sv
module mpr_seq #(
    parameter int ROW_W      = 24,
    parameter int COL_W      = 14,
    parameter int PAGE_BITS  = 8,
    parameter int PAGE_BYTES = 8640,
    parameter int TMO_CYCLES = 12000,
    parameter int WB_CYCLES  = 4,
    parameter int WHR_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ROW_W-1:0] row_a_i,
    input  logic [ROW_W-1:0] row_b_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [COL_W-1:0] cnt_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       status_o,
    output logic             nand_cle_o,
    output logic             nand_ale_o,
    output logic             nand_we_n_o,
    output logic             nand_re_n_o,
    output logic [7:0]       nand_io_o,
    output logic             nand_io_oe_o,
    input  logic [7:0]       nand_io_i,
    input  logic             nand_rb_n_i,
    output logic             rd_valid_o,
    output logic [7:0]       rd_data_o,
    output logic             rd_plane_o,
    output logic             rd_last_o
);
    import mpr_pkg::*;

    localparam int RB          = ROW_W / 8;
    localparam int SETUP_LEN   = 2 * RB + 3;
    localparam int UNLOAD_LEN  = RB + 7;
    localparam int IDX_W       = $clog2(UNLOAD_LEN + 1);
    localparam int TW          = $clog2(TMO_CYCLES + 1);
    localparam logic [IDX_W-1:0] SETUP_LAST  = IDX_W'(SETUP_LEN - 1);
    localparam logic [IDX_W-1:0] UNLOAD_LAST = IDX_W'(UNLOAD_LEN - 1);

    mpr_state_e       state, state_n;
    mpr_status_e      status, status_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic             ph, ph_n;
    logic             plane, plane_n;
    logic [COL_W-1:0] rd_left, rd_left_n;
    logic [ROW_W-1:0] row_a_q, row_b_q;
    logic [COL_W-1:0] col_q, cnt_q;
    logic             take;
    logic             rb_q;
    logic             req_ok;
    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             tmr_done;
    logic             step_cmd;
    logic [7:0]       step_byte;

    mpr_req_check #(
        .ROW_W(ROW_W), .COL_W(COL_W), .PAGE_BITS(PAGE_BITS), .PAGE_BYTES(PAGE_BYTES)
    ) u_check (
        .row_a(row_a_i), .row_b(row_b_i), .col(col_i), .cnt(cnt_i), .ok(req_ok)
    );

    mpr_step_rom #(
        .ROW_W(ROW_W), .COL_W(COL_W), .IDX_W(IDX_W)
    ) u_rom (
        .unload(state == S_UNLOAD), .idx(idx), .row_a(row_a_q), .row_b(row_b_q),
        .plane(plane), .col(col_q), .is_cmd(step_cmd), .byte_o(step_byte)
    );

    mpr_wait_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
    );

    // next-state and control decisions
    always_comb begin
        state_n   = state;
        status_n  = status;
        idx_n     = idx;
        ph_n      = ph;
        plane_n   = plane;
        rd_left_n = rd_left;
        take      = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state)
            S_IDLE: begin
                if (start_i) begin
                    take    = 1'b1;
                    idx_n   = '0;
                    ph_n    = 1'b0;
                    plane_n = 1'b0;
                    if (req_ok) begin
                        state_n = S_SETUP;
                    end else begin
                        status_n = ST_BADREQ;
                        state_n  = S_DONE;
                    end
                end
            end
            S_SETUP: begin
                if (!ph) begin
                    ph_n = 1'b1;
                end else begin
                    ph_n = 1'b0;
                    if (idx == SETUP_LAST) begin
                        state_n  = S_WB;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(WB_CYCLES);
                    end else begin
                        idx_n = idx + 1'b1;
                    end
                end
            end
            S_WB: begin
                if (tmr_done) begin
                    state_n  = S_BUSY;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TMO_CYCLES);
                end
            end
            S_BUSY: begin
                if (rb_q) begin
                    state_n = S_UNLOAD;
                    idx_n   = '0;
                    ph_n    = 1'b0;
                end else if (tmr_done) begin
                    status_n = ST_TIMEOUT;
                    state_n  = S_DONE;
                end
            end
            S_UNLOAD: begin
                if (!ph) begin
                    ph_n = 1'b1;
                end else begin
                    ph_n = 1'b0;
                    if (idx == UNLOAD_LAST) begin
                        state_n  = S_WHR;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(WHR_CYCLES);
                    end else begin
                        idx_n = idx + 1'b1;
                    end
                end
            end
            S_WHR: begin
                if (tmr_done) begin
                    state_n   = S_READ;
                    ph_n      = 1'b0;
                    rd_left_n = cnt_q;
                end
            end
            S_READ: begin
                if (!ph) begin
                    ph_n = 1'b1;
                end else begin
                    ph_n      = 1'b0;
                    rd_left_n = rd_left - 1'b1;
                    if (rd_left == COL_W'(1)) begin
                        if (!plane) begin
                            plane_n = 1'b1;
                            idx_n   = '0;
                            state_n = S_UNLOAD;
                        end else begin
                            status_n = ST_OK;
                            state_n  = S_DONE;
                        end
                    end
                end
            end
            S_DONE: begin
                state_n = S_IDLE;
            end
            default: begin
                state_n = S_IDLE;
            end
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            status     <= ST_OK;
            idx        <= '0;
            ph         <= 1'b0;
            plane      <= 1'b0;
            rd_left    <= '0;
            row_a_q    <= '0;
            row_b_q    <= '0;
            col_q      <= '0;
            cnt_q      <= '0;
            rb_q       <= 1'b0;
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            rd_plane_o <= 1'b0;
            rd_last_o  <= 1'b0;
        end else begin
            state   <= state_n;
            status  <= status_n;
            idx     <= idx_n;
            ph      <= ph_n;
            plane   <= plane_n;
            rd_left <= rd_left_n;
            rb_q    <= nand_rb_n_i;
            if (take) begin
                row_a_q <= row_a_i;
                row_b_q <= row_b_i;
                col_q   <= col_i;
                cnt_q   <= cnt_i;
            end
            if (state == S_READ && !ph) begin
                rd_valid_o <= 1'b1;
                rd_data_o  <= nand_io_i;
                rd_plane_o <= plane;
                rd_last_o  <= (rd_left == COL_W'(1));
            end else begin
                rd_valid_o <= 1'b0;
                rd_last_o  <= 1'b0;
            end
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        nand_cle_o   = 1'b0;
        nand_ale_o   = 1'b0;
        nand_we_n_o  = 1'b1;
        nand_re_n_o  = 1'b1;
        nand_io_oe_o = 1'b0;
        nand_io_o    = 8'h00;
        if (state == S_SETUP || state == S_UNLOAD) begin
            nand_io_oe_o = 1'b1;
            nand_io_o    = step_byte;
            nand_cle_o   = step_cmd;
            nand_ale_o   = !step_cmd;
            nand_we_n_o  = ph;
        end else if (state == S_READ) begin
            nand_re_n_o = ph;
        end
        busy_o   = (state != S_IDLE);
        done_o   = (state == S_DONE);
        status_o = status;
    end
endmodule

// File: rtl/mpr_seq_chk.sv
module mpr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic [1:0] status_o,
    input logic       nand_cle_o,
    input logic       nand_ale_o,
    input logic       nand_we_n_o,
    input logic       nand_re_n_o,
    input logic       nand_io_oe_o,
    input logic       nand_rb_n_i,
    input logic       rd_valid_o,
    input logic       rd_last_o
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (nand_we_n_o && nand_re_n_o && !nand_io_oe_o && !nand_cle_o && !nand_ale_o));

    assert_latch_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle_o && nand_ale_o));

    assert_read_only_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n_o |-> nand_rb_n_i);

    assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 2'd1) |-> (nand_we_n_o && $past(nand_we_n_o)));

    assert_last_has_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last_o |-> rd_valid_o);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
endmodule

bind mpr_seq mpr_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
    .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o), .nand_we_n_o(nand_we_n_o),
    .nand_re_n_o(nand_re_n_o), .nand_io_oe_o(nand_io_oe_o), .nand_rb_n_i(nand_rb_n_i),
    .rd_valid_o(rd_valid_o), .rd_last_o(rd_last_o)
);

// File: tb/mpr_seq_test.sv
module mpr_seq_test;
    localparam int TMO = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] row_a = '0, row_b = '0;
    logic [13:0] col = '0, cnt = '0;
    logic        busy, done, cle, ale, we_n, re_n, oe, rd_valid, rd_plane, rd_last;
    logic [1:0]  status;
    logic [7:0]  io_out, io_in, rd_data;
    logic        rb_n = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    mpr_seq #(.TMO_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .row_a_i(row_a), .row_b_i(row_b),
        .col_i(col), .cnt_i(cnt), .busy_o(busy), .done_o(done), .status_o(status),
        .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_n_o(we_n), .nand_re_n_o(re_n),
        .nand_io_o(io_out), .nand_io_oe_o(oe), .nand_io_i(io_in), .nand_rb_n_i(rb_n),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_plane_o(rd_plane), .rd_last_o(rd_last)
    );

    // ---------------- device model ----------------
    logic [8:0]  log_q [$];
    logic [8:0]  exp_q [$];
    logic [9:0]  strm_q [$];
    logic [7:0]  abuf [8];
    int          acnt = 0;
    int          cfm_events = 0, cfm_seen = 0;
    int          busy_left = 0, busy_len = 10;
    bit          hang = 0;
    bit          early = 0;
    logic        mdl_plane = 1'b0;
    logic [13:0] mdl_base = '0;
    int          re_total = 0, re_mark = 0;

    function automatic logic [7:0] data_fn(logic p, logic [13:0] c);
        return c[7:0] ^ {c[13:8], 2'b01} ^ (p ? 8'hA5 : 8'h3C);
    endfunction

    assign io_in = data_fn(mdl_plane, mdl_base + 14'(re_total - re_mark));

    always @(posedge we_n) begin
        if (cle) begin
            log_q.push_back({1'b1, io_out});
            if (io_out == 8'h30) cfm_events <= cfm_events + 1;
            if (io_out == 8'h00 && !rb_n) early <= 1;
            if (io_out == 8'h05) mdl_plane <= abuf[3][0];
            if (io_out == 8'hE0) begin
                mdl_base <= {abuf[1][5:0], abuf[0]};
                re_mark  <= re_total;
            end
            acnt <= 0;
        end else if (ale) begin
            log_q.push_back({1'b0, io_out});
            abuf[acnt[2:0]] <= io_out;
            acnt <= acnt + 1;
        end
    end

    always @(posedge re_n) re_total <= re_total + 1;

    always @(posedge clk) begin
        if (cfm_events != cfm_seen) begin
            cfm_seen  <= cfm_events;
            rb_n      <= 1'b0;
            busy_left <= busy_len;
        end else if (!rb_n && !hang) begin
            if (busy_left <= 1) rb_n <= 1'b1;
            else busy_left <= busy_left - 1;
        end
    end

    always @(negedge clk) begin
        if (rd_valid) strm_q.push_back({rd_last, rd_plane, rd_data});
        if (!re_n && !rb_n) early <= 1;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic int exp_status(logic [23:0] a, logic [23:0] b, logic [13:0] c, logic [13:0] n, bit hg);
        if (a[8] || b != (a | 24'h000100)) return 1;
        if (n == 0 || c >= 14'd8640 || (int'(c) + int'(n)) > 8640) return 1;
        return hg ? 2 : 0;
    endfunction

    task automatic build_exp(input logic [23:0] a, input logic [23:0] b, input logic [13:0] c, input bit full);
        exp_q.delete();
        exp_q.push_back(9'h160);
        for (int k = 0; k < 3; k++) exp_q.push_back({1'b0, a[8*k +: 8]});
        exp_q.push_back(9'h160);
        for (int k = 0; k < 3; k++) exp_q.push_back({1'b0, b[8*k +: 8]});
        exp_q.push_back(9'h130);
        if (full) begin
            for (int p = 0; p < 2; p++) begin
                logic [23:0] r;
                r = (p == 0) ? a : b;
                exp_q.push_back(9'h100);
                exp_q.push_back({1'b0, c[7:0]});
                exp_q.push_back({3'b0, c[13:8]});
                for (int k = 0; k < 3; k++) exp_q.push_back({1'b0, r[8*k +: 8]});
                exp_q.push_back(9'h105);
                exp_q.push_back({1'b0, c[7:0]});
                exp_q.push_back({3'b0, c[13:8]});
                exp_q.push_back(9'h1E0);
            end
        end
    endtask

    task automatic run_req(input logic [23:0] a, input logic [23:0] b, input logic [13:0] c,
                           input logic [13:0] n, input int blen, input bit hg, input string tag);
        int es, wait_cyc, bad, nint;
        log_q.delete();
        strm_q.delete();
        early    = 0;
        busy_len = blen;
        hang     = hg;
        es       = exp_status(a, b, c, n, hg);
        @(negedge clk);
        row_a = a; row_b = b; col = c; cnt = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cyc = 0;
        while (!done) begin
            @(negedge clk);
            wait_cyc++;
            if (wait_cyc > 20000) begin
                chk(0, tag, "watchdog expired waiting for done", wait_cyc, 20000);
                finish_run();
            end
        end
        chk(int'(status) == es, tag, "status", int'(status), es);
        @(negedge clk);
        chk(!done && !busy, "R9", "done single pulse then idle", int'({done, busy}), 0);
        nint = int'(n);
        if (es == 1) begin
            chk(log_q.size() == 0, tag, "bus bytes on rejected request", log_q.size(), 0);
            chk(strm_q.size() == 0, tag, "stream bytes on rejected request", strm_q.size(), 0);
        end else begin
            build_exp(a, b, c, es == 0);
            bad = 0;
            if (log_q.size() != exp_q.size()) bad = 1000;
            else foreach (log_q[i]) if (log_q[i] !== exp_q[i]) bad++;
            chk(bad == 0, (es == 0) ? "R4/R7" : "R4/R6", "command/address log mismatches",
                bad, 0);
            chk(!early, "R5", "activity while ready/busy low", int'(early), 0);
            if (es == 2) begin
                chk(strm_q.size() == 0, "R6", "stream bytes after timeout", strm_q.size(), 0);
            end else begin
                chk(strm_q.size() == 2 * nint, "R8", "stream length", strm_q.size(), 2 * nint);
                bad = 0;
                if (strm_q.size() == 2 * nint) begin
                    foreach (strm_q[k]) begin
                        logic        p;
                        logic [13:0] cc;
                        logic [9:0]  e;
                        p  = (k >= nint);
                        cc = c + 14'(k % nint);
                        e  = {(k % nint) == nint - 1, p, data_fn(p, cc)};
                        if (strm_q[k] !== e) bad++;
                    end
                end
                chk(bad == 0, "R8", "stream byte/plane/last mismatches", bad, 0);
            end
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(we_n && re_n && !cle && !ale && !oe && !busy && !done && !rd_valid, "R1",
            "idle outputs in reset", int'({we_n, re_n, cle, ale, oe, busy, done, rd_valid}), 8'hC0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(we_n && re_n && !cle && !ale && !oe && !busy && !done && !rd_valid, "R1",
            "idle outputs after reset", int'({we_n, re_n, cle, ale, oe, busy, done, rd_valid}), 8'hC0);

        // directed main cases
        run_req(24'h012A37, 24'h012B37, 14'd100, 14'd5, 30, 0, "R4");
        run_req(24'h3C4E12, 24'h3C4F12, 14'd8639, 14'd1, 8, 0, "R3");
        run_req(24'h000000, 24'h000100, 14'd8600, 14'd40, 50, 0, "R3");
        // rejections
        run_req(24'h012A37, 24'h012B38, 14'd0, 14'd4, 10, 0, "R2");
        run_req(24'h012A37, 24'h013B37, 14'd0, 14'd4, 10, 0, "R2");
        run_req(24'h012B37, 24'h012B37, 14'd0, 14'd4, 10, 0, "R2");
        run_req(24'h000200, 24'h000300, 14'd8601, 14'd40, 10, 0, "R3");
        run_req(24'h000200, 24'h000300, 14'd8640, 14'd1, 10, 0, "R3");
        run_req(24'h000200, 24'h000300, 14'd10, 14'd0, 10, 0, "R3");

        // constrained random good requests
        for (int t = 0; t < 10; t++) begin
            logic [23:0] a;
            logic [13:0] c, n;
            int room;
            a    = $urandom;
            a[8] = 1'b0;
            c    = 14'($urandom_range(0, 8639));
            room = 8640 - int'(c);
            n    = 14'($urandom_range(1, (room < 40) ? room : 40));
            run_req(a, a | 24'h000100, c, n, $urandom_range(5, 200), 0, "R8");
        end

        // timeout last: ready/busy never rises
        run_req(24'h055A01, 24'h055B01, 14'd12, 14'd3, 10, 1, "R6");

        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "R9", "global watchdog expired", 0, 1);
        finish_run();
    end
endmodule